// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block sits on the byte-write path of a byte-wide non-volatile memory. It watches each host write (address and data) and picks out two fixed command sequences. The three-write arming sequence turns software write protection on. The six-write release sequence turns it off. For every write it gives a same-cycle permit that says whether the byte may reach the array. It also reports the current protection state, and whether a command sequence is partly received.

While protection is on, ordinary writes are refused. The command writes themselves are refused too. The single exception is a page burst that directly follows a complete arming sequence: up to `PAGE_BYTES` writes on one page are let through. That page is the page of the first write after the sequence.

The protection flag has its own power-on reset `por`. The functional reset `rst` clears only the sequence tracker and the burst window. This lets the flag model a non-volatile latch that survives ordinary resets.

Top module: `wp_unlock_detector`

## Requirements
- R1: After `por`, `prot_on` is 0 and every write gets `wr_permit` = 1 until an arming sequence completes.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, received in that order as consecutive writes, set `prot_on` from the clock edge that takes the third write.
- R3: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 20h@555h, received in that order, clear `prot_on` from the clock edge that takes the sixth write.
- R4: While `prot_on` is 1 and no burst window is open, every write gets `wr_permit` = 0.
- R5: A write that is taken as part of a command sequence gets `wr_permit` = 1 when protection is off and 0 when it is on.
- R6: After an arming sequence, the next write opens a burst on its page (address bits 10..6). Up to `PAGE_BYTES` (default 64) writes on that page get `wr_permit` = 1. The write after the last of them is judged as an ordinary write.
- R7: Inside a burst, a write to a different page ends the burst. That write is judged as an ordinary write (refused while protected), and later writes to the burst's page are refused as well.
- R8: A write that does not match the next expected step returns the tracker to idle (`seq_busy` = 0). That write is judged as an ordinary write, and `prot_on` is left unchanged.
- R9: `rst` clears the tracker and the burst window but leaves `prot_on` unchanged. A sequence that `rst` interrupts does not complete.
- R10: `seq_busy` is 1 from the edge that accepts the first write of a sequence until the sequence completes or breaks.
- R11: Cycles with `wr_valid` = 0 between the writes of a sequence do not change the tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high functional reset (tracker, burst window) |
| por | input | 1 | Synchronous active-high power-on reset of the protection flag |
| wr_valid | input | 1 | A host byte write is present this cycle |
| wr_addr | input | ADDR_W (11) | Byte address of the write |
| wr_data | input | DATA_W (8) | Data byte of the write |
| wr_permit | output | 1 | This write may be committed to the array (combinational) |
| prot_on | output | 1 | Software write protection is active |
| seq_busy | output | 1 | A command sequence is partly received |

## Verification
The in-RTL assertions check the following on every cycle:
- the flag follows the arming and release completions and holds otherwise;
- the tracker holds on cycles without a write and falls to idle on a mismatch;
- the burst counter stays in bounds and the window closes on a foreign page;
- a protected write outside a window is never permitted.

Only the bench scenarios can show whether the exact command patterns are recognised. The same holds for breaking a sequence at each of its steps, for the exact burst length, and for the flag surviving `rst` but not `por`.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_D3,
        ST_D4,
        ST_D5
    } seq_st_t;

    localparam logic [10:0] ADR_HI  = 11'h555;
    localparam logic [10:0] ADR_LO  = 11'h2AA;
    localparam logic [7:0]  K_A     = 8'hAA;
    localparam logic [7:0]  K_B     = 8'h55;
    localparam logic [7:0]  K_ARM   = 8'hA0;
    localparam logic [7:0]  K_REL   = 8'h80;
    localparam logic [7:0]  K_FIN   = 8'h20;

    typedef struct packed {
        logic    step;
        logic    arm_done;
        logic    rel_done;
        seq_st_t nxt;
    } seq_res_t;

    function automatic seq_res_t seq_step(seq_st_t st, logic [10:0] a, logic [7:0] d);
        seq_res_t r;
        r.step     = 1'b1;
        r.arm_done = 1'b0;
        r.rel_done = 1'b0;
        r.nxt      = ST_IDLE;
        case (st)
            ST_IDLE: if (a == ADR_HI && d == K_A) r.nxt = ST_K1; else r.step = 1'b0;
            ST_K1:   if (a == ADR_LO && d == K_B) r.nxt = ST_K2; else r.step = 1'b0;
            ST_K2: begin
                if (a == ADR_HI && d == K_ARM)      r.arm_done = 1'b1;
                else if (a == ADR_HI && d == K_REL) r.nxt = ST_D3;
                else                                r.step = 1'b0;
            end
            ST_D3:   if (a == ADR_HI && d == K_A) r.nxt = ST_D4; else r.step = 1'b0;
            ST_D4:   if (a == ADR_LO && d == K_B) r.nxt = ST_D5; else r.step = 1'b0;
            ST_D5:   if (a == ADR_HI && d == K_FIN) r.rel_done = 1'b1; else r.step = 1'b0;
            default: r.step = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wp_seq_tracker.sv
module wp_seq_tracker
    import wp_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_hit,
    output logic              arm_done,
    output logic              rel_done,
    output logic              busy
);

    seq_st_t  st_q;
    seq_res_t res;
    logic     addr_ok;

    always_comb begin
        addr_ok = ((wr_addr >> 11) == '0);
        res     = seq_step(st_q, wr_addr[10:0], wr_data[7:0]);
        if (!addr_ok) begin
            res.step     = 1'b0;
            res.arm_done = 1'b0;
            res.rel_done = 1'b0;
            res.nxt      = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        st_q <= ST_IDLE;
        else if (wr_en) st_q <= res.nxt;
    end

    assign cmd_hit  = wr_en & res.step;
    assign arm_done = wr_en & res.arm_done;
    assign rel_done = wr_en & res.rel_done;
    assign busy     = (st_q != ST_IDLE);

    // R11: no write, no movement
    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q));
    // R8: a rejected write leaves the tracker idle
    p_break_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmd_hit) |=> (st_q == ST_IDLE));
    // R2/R3: never both completions at once
    p_one_done_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arm_done, rel_done}));

endmodule

// File: rtl/wp_page_window.sv
module wp_page_window #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_req,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              win_hit,
    output logic              win_open
);

    localparam int PAGE_LSB = $clog2(PAGE_BYTES);
    localparam int PG_W     = ADDR_W - PAGE_LSB;
    localparam int CNT_W    = $clog2(PAGE_BYTES + 1);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PG_W-1:0]  page_q;
    logic [PG_W-1:0]  page_in;
    logic             first;

    assign page_in  = wr_addr[ADDR_W-1:PAGE_LSB];
    assign first    = (cnt_q == '0);
    assign win_hit  = wr_valid & open_q & (first | (page_in == page_q));
    assign win_open = open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            page_q <= '0;
        end else if (open_req) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
        end else if (wr_valid && open_q) begin
            if (win_hit) begin
                cnt_q <= cnt_q + 1'b1;
                if (first) page_q <= page_in;
                if (cnt_q == CNT_W'(PAGE_BYTES - 1)) open_q <= 1'b0;
            end else begin
                open_q <= 1'b0;
            end
        end
    end

    // R6: burst count stays below the page size while open
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        open_q |-> (cnt_q < CNT_W'(PAGE_BYTES)));
    // R7: a foreign-page write closes the burst
    p_close_on_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && open_q && !win_hit && !open_req) |=> !open_q);

endmodule

// File: rtl/wp_prot_latch.sv
module wp_prot_latch (
    input  logic clk,
    input  logic por,
    input  logic set_i,
    input  logic clr_i,
    output logic prot
);

    always_ff @(posedge clk) begin
        if (por)        prot <= 1'b0;
        else if (set_i) prot <= 1'b1;
        else if (clr_i) prot <= 1'b0;
    end

    // R2: arming completes -> protected next cycle
    p_arm_sets_r2: assert property (@(posedge clk) disable iff (por)
        set_i |=> prot);
    // R3: release completes -> unprotected next cycle
    p_rel_clears_r3: assert property (@(posedge clk) disable iff (por)
        (clr_i && !set_i) |=> !prot);
    // R9: flag holds without a completion
    p_hold_r9: assert property (@(posedge clk) disable iff (por)
        (!set_i && !clr_i) |=> $stable(prot));

endmodule

// File: rtl/wp_unlock_detector.sv
module wp_unlock_detector #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_permit,
    output logic              prot_on,
    output logic              seq_busy
);

    logic win_hit, win_open;
    logic trk_en, cmd_hit, arm_done, rel_done;

    assign trk_en = wr_valid & ~win_hit;

    wp_page_window #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_win (
        .clk(clk), .rst(rst), .open_req(arm_done), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .win_hit(win_hit), .win_open(win_open)
    );

    wp_seq_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
        .clk(clk), .rst(rst), .wr_en(trk_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_hit(cmd_hit), .arm_done(arm_done), .rel_done(rel_done), .busy(seq_busy)
    );

    wp_prot_latch u_prot (
        .clk(clk), .por(por), .set_i(arm_done), .clr_i(rel_done), .prot(prot_on)
    );

    assign wr_permit = win_hit | (trk_en & ~prot_on);

    // R4: protected write outside a burst is never permitted
    p_block_locked_r4: assert property (@(posedge clk) disable iff (rst || por)
        (wr_valid && prot_on && !win_open) |-> !wr_permit);
    // R5: sequence writes follow the protection flag
    p_cmd_follows_prot_r5: assert property (@(posedge clk) disable iff (rst || por)
        (cmd_hit && prot_on) |-> !wr_permit);

endmodule

// File: tb/wp_unlock_detector_bench.sv
`timescale 1ns/1ps
module wp_unlock_detector_bench;

    logic        clk = 1'b0;
    logic        rst, por, wr_valid;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_permit, prot_on, seq_busy;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    wp_unlock_detector u_wp_unlock_detector (
        .clk(clk), .rst(rst), .por(por), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_permit(wr_permit), .prot_on(prot_on), .seq_busy(seq_busy)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one write cycle; permit sampled mid-cycle, ends at negedge with valid low
    task automatic wr(logic [10:0] a, logic [7:0] d, logic exp, string req);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 chk(req, wr_permit, exp);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit do_rst, bit do_por);
        @(negedge clk);
        rst = do_rst; por = do_por;
        @(negedge clk);
        rst = 1'b0; por = 1'b0;
    endtask

    task automatic arm(logic exp);
        wr(11'h555, 8'hAA, exp, "R5");
        wr(11'h2AA, 8'h55, exp, "R5");
        wr(11'h555, 8'hA0, exp, "R5");
    endtask

    task automatic release_seq(logic exp, int gap);
        wr(11'h555, 8'hAA, exp, "R5"); idle(gap);
        wr(11'h2AA, 8'h55, exp, "R5"); idle(gap);
        wr(11'h555, 8'h80, exp, "R5"); idle(gap);
        chk("R11", seq_busy, 1'b1);
        wr(11'h555, 8'hAA, exp, "R5"); idle(gap);
        wr(11'h2AA, 8'h55, exp, "R5"); idle(gap);
        wr(11'h555, 8'h20, exp, "R5");
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] seq_a [6];
        logic [7:0]  seq_d [6];
        seq_a = '{11'h555, 11'h2AA, 11'h555, 11'h555, 11'h2AA, 11'h555};
        seq_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
        rst = 1'b1; por = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        idle(3);
        rst = 1'b0; por = 1'b0;
        idle(1);
        chk("R1", prot_on, 1'b0);
        chk("R10", seq_busy, 1'b0);

        // R1: unprotected sweep
        for (int a = 0; a < 2048; a += 37)
            wr(11'(a), 8'(a) ^ 8'h3C, 1'b1, "R1");

        // R2 / R10: arming while unprotected
        wr(11'h555, 8'hAA, 1'b1, "R5");
        chk("R10", seq_busy, 1'b1);
        wr(11'h2AA, 8'h55, 1'b1, "R5");
        chk("R10", seq_busy, 1'b1);
        wr(11'h555, 8'hA0, 1'b1, "R5");
        chk("R2", prot_on, 1'b1);
        chk("R10", seq_busy, 1'b0);

        // R6: full burst then one over
        for (int i = 0; i < 64; i++)
            wr(11'((3 << 6) + i), 8'(i), 1'b1, "R6");
        wr(11'((3 << 6) + 5), 8'h11, 1'b0, "R6");

        // R4: protected sweep
        for (int a = 0; a < 2048; a += 29)
            wr(11'(a), 8'(a) ^ 8'h5A, 1'b0, "R4");

        // R9: functional reset keeps protection
        pulse(1'b1, 1'b0);
        chk("R9", prot_on, 1'b1);
        wr(11'h010, 8'h01, 1'b0, "R9");

        // R5 / R7: arm again while protected, foreign page ends burst
        arm(1'b0);
        wr(11'((5 << 6) + 1), 8'h21, 1'b1, "R6");
        wr(11'((5 << 6) + 2), 8'h22, 1'b1, "R6");
        wr(11'((6 << 6) + 2), 8'h23, 1'b0, "R7");
        wr(11'((5 << 6) + 3), 8'h24, 1'b0, "R7");

        // R8: break the release sequence at every step
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < k; j++)
                wr(seq_a[j], seq_d[j], 1'b0, "R5");
            wr(seq_a[k], seq_d[k] ^ 8'h01, 1'b0, "R8");
            chk("R8", seq_busy, 1'b0);
            chk("R8", prot_on, 1'b1);
        end

        // R3 / R11: release with idle gaps
        release_seq(1'b0, 2);
        chk("R3", prot_on, 1'b0);
        wr(11'h123, 8'h45, 1'b1, "R3");

        // R9: reset interrupts arming
        wr(11'h555, 8'hAA, 1'b1, "R5");
        wr(11'h2AA, 8'h55, 1'b1, "R5");
        pulse(1'b1, 1'b0);
        chk("R9", seq_busy, 1'b0);
        wr(11'h555, 8'hA0, 1'b1, "R9");
        chk("R9", prot_on, 1'b0);

        // R1: power-on clears protection
        arm(1'b1);
        chk("R2", prot_on, 1'b1);
        pulse(1'b1, 1'b1);
        chk("R1", prot_on, 1'b0);
        wr(11'h7C0, 8'h99, 1'b1, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule